// File: doc/BRIEF.md
# Dependence-Aware Memory Issue Queue Wakeup

This block holds the memory-operation part of an out-of-order issue queue. At dispatch each load is written into a slot together with the dependence verdict made for it at that moment. The verdict is one of three: issue freely, wait for one named store, or wait for every older store. For the named-store case the slot also keeps that store's ROB tag. After dispatch the verdict lives only in the slot, so no lookup path back to the predictor is needed.

Two kinds of information reach the block every cycle. One is a broadcast carrying the ROB tag of a store that has just resolved its address. The other is the tag of the oldest store whose address is still unresolved, with a valid flag. From these, and from the current ROB head pointer, each slot works out whether it may issue. A selector then grants the single oldest ready slot. A flush tag removes every slot younger than it.

Top module: `mdq_wakeup`

## Requirements
- R1: After reset no slot is occupied: `issue_valid_o` is 0 and `disp_ready_o` is 1.
- R2: A slot dispatched with verdict code 0 (free) may issue even while an older store is unresolved.
- R3: A slot dispatched with verdict code 1 (wait-for) stays blocked until a resolve broadcast carries its recorded store tag. Broadcasts with other tags have no effect. One broadcast wakes every slot holding that tag.
- R4: Once woken, a wait-for slot behaves as a free slot: it issues even though older stores stay unresolved.
- R5: A resolve broadcast in the same cycle as the dispatch of a matching wait-for load wakes the new slot at once.
- R6: A slot with verdict code 2 (wait-all), or with the spare code 3 (handled the same way), may issue only when `old_st_valid_i` is 0 or `old_st_tag_i` is younger than the slot's tag.
- R7: Age is measured as (tag − `rob_head_i`) modulo 2^TAG_W. At most one slot issues per cycle, and it is the oldest ready slot. An issued slot is freed.
- R8: While `flush_valid_i` is high, every slot younger than `flush_tag_i` is removed and never issues, including in that same cycle. The flush tag and older slots are kept. A dispatch younger than the flush tag is dropped.
- R9: `disp_ready_o` is 0 when all DEPTH slots are occupied. A dispatch offered while it is 0 is ignored.
- R10: A dispatched slot can issue at the earliest in the cycle after its dispatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disp_valid_i | input | 1 | Load dispatch request |
| disp_rob_tag_i | input | TAG_W | ROB tag of the dispatched load |
| disp_pred_i | input | 2 | Verdict: 0 free, 1 wait-for, 2 wait-all, 3 treated as wait-all |
| disp_store_tag_i | input | TAG_W | Store tag awaited by a wait-for load |
| disp_ready_o | output | 1 | A free slot exists |
| st_res_valid_i | input | 1 | A store resolved its address this cycle |
| st_res_tag_i | input | TAG_W | ROB tag of that store |
| old_st_valid_i | input | 1 | Some store is still unresolved |
| old_st_tag_i | input | TAG_W | ROB tag of the oldest unresolved store |
| rob_head_i | input | TAG_W | ROB head tag, the age origin |
| flush_valid_i | input | 1 | Squash request |
| flush_tag_i | input | TAG_W | Slots younger than this are removed |
| issue_valid_o | output | 1 | A load issues this cycle |
| issue_rob_tag_o | output | TAG_W | ROB tag of the issuing load |

## Verification
Several rules are checked by assertions in every cycle. A wait-for slot without a matching broadcast stays blocked, and a woken slot stays ready until it issues or is flushed. A flushed slot is empty one cycle later, and at most one grant is raised, always to a ready slot. A full queue ignores a dispatch. Other behaviour can only be shown by the bench's scenarios. This covers oldest-first order across the tag wrap point and which tag wakes which slot. It also covers same-cycle wakeup at dispatch, the boundary of the wait-all rule, and the masking of issue in a flush cycle.

// File: rtl/mdq_pkg.sv
// Package mdq_pkg: the dependence verdict encoding shared by every module of
// the memory wakeup queue. The codes match the dispatch port encoding.
package mdq_pkg;
    typedef enum logic [1:0] {
        PRED_BYPASS  = 2'd0,
        PRED_WAITFOR = 2'd1,
        PRED_WAITALL = 2'd2,
        PRED_RSVD    = 2'd3
    } mdq_pred_e;
endpackage

// File: rtl/mdq_slot.sv
// mdq_slot: one queue entry. Holds the load's ROB tag, the verdict cached at
// dispatch and, for wait-for, the awaited store tag. Computes its own flush
// kill and readiness. Assumes alloc_i only targets an empty slot and that
// issue_i is only raised when ready_o is high.
module mdq_slot
    import mdq_pkg::*;
#(
    parameter int TAG_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_i,
    input  logic [TAG_W-1:0] alloc_tag_i,
    input  mdq_pred_e        alloc_pred_i,
    input  logic [TAG_W-1:0] alloc_stag_i,
    input  logic             res_valid_i,
    input  logic [TAG_W-1:0] res_tag_i,
    input  logic             old_st_valid_i,
    input  logic [TAG_W-1:0] old_st_tag_i,
    input  logic [TAG_W-1:0] rob_head_i,
    input  logic             flush_valid_i,
    input  logic [TAG_W-1:0] flush_tag_i,
    input  logic             issue_i,
    output logic             valid_o,
    output logic [TAG_W-1:0] tag_o,
    output logic             ready_o
);
    logic             valid_q;
    logic [TAG_W-1:0] tag_q;
    logic [TAG_W-1:0] stag_q;
    mdq_pred_e        st_q;
    logic [TAG_W-1:0] my_age, old_age, flush_age;
    logic             kill, wake, alloc_wake, older_clear;
    mdq_pred_e        alloc_state;

    // Ages relative to the ROB head for flush and wait-all comparisons.
    always_comb begin
        my_age    = tag_q - rob_head_i;
        old_age   = old_st_tag_i - rob_head_i;
        flush_age = flush_tag_i - rob_head_i;
    end

    // Kill, wake and readiness decisions of this slot.
    always_comb begin
        kill        = valid_q && flush_valid_i && (my_age > flush_age);
        wake        = valid_q && (st_q == PRED_WAITFOR) && res_valid_i && (res_tag_i == stag_q);
        older_clear = !old_st_valid_i || (old_age > my_age);
        ready_o     = valid_q && !kill &&
                      ((st_q == PRED_BYPASS) || ((st_q == PRED_WAITALL) && older_clear));
    end

    // State written at dispatch, including same-cycle wakeup and spare-code folding.
    always_comb begin
        alloc_wake = res_valid_i && (res_tag_i == alloc_stag_i);
        case (alloc_pred_i)
            PRED_BYPASS:  alloc_state = PRED_BYPASS;
            PRED_WAITFOR: alloc_state = alloc_wake ? PRED_BYPASS : PRED_WAITFOR;
            default:      alloc_state = PRED_WAITALL;
        endcase
    end

    // Slot storage: free on issue or kill, load on alloc, promote on wake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            tag_q   <= '0;
            stag_q  <= '0;
            st_q    <= PRED_BYPASS;
        end else if (kill || issue_i) begin
            valid_q <= 1'b0;
        end else if (alloc_i) begin
            valid_q <= 1'b1;
            tag_q   <= alloc_tag_i;
            stag_q  <= alloc_stag_i;
            st_q    <= alloc_state;
        end else if (wake) begin
            st_q    <= PRED_BYPASS;
        end
    end

    assign valid_o = valid_q;
    assign tag_o   = tag_q;

    // R3
    waitfor_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && st_q == PRED_WAITFOR && !flush_valid_i &&
         !(res_valid_i && res_tag_i == stag_q)) |=> (valid_q && st_q == PRED_WAITFOR));

    // R4
    woken_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && st_q == PRED_BYPASS && !flush_valid_i && !issue_i)
        |=> (valid_q && st_q == PRED_BYPASS));

    // R8
    flush_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && flush_valid_i && ((tag_q - rob_head_i) > (flush_tag_i - rob_head_i)))
        |=> !valid_q);
endmodule

// File: rtl/mdq_alloc.sv
// mdq_alloc: chooses the lowest-index empty slot for a dispatch and reports
// whether any slot is free. Assumes valid_i reflects registered slot state.
module mdq_alloc #(
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEPTH-1:0] valid_i,
    input  logic             fire_i,
    output logic [DEPTH-1:0] alloc_o,
    output logic             ready_o
);
    logic [DEPTH-1:0] pick;

    // Priority encoder over empty slots, lowest index first.
    always_comb begin
        pick = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!valid_i[i] && (pick == '0)) pick[i] = 1'b1;
        end
    end

    assign ready_o = |(~valid_i);
    assign alloc_o = fire_i ? pick : '0;

    // R9
    alloc_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((alloc_o & valid_i) == '0) && $onehot0(alloc_o));
endmodule

// File: rtl/mdq_oldest.sv
// mdq_oldest: grants the ready slot with the smallest age relative to the ROB
// head, one per cycle. Assumes tags of live slots are distinct.
module mdq_oldest #(
    parameter int DEPTH = 8,
    parameter int TAG_W = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [DEPTH-1:0]            ready_i,
    input  logic [DEPTH-1:0][TAG_W-1:0] tags_i,
    input  logic [TAG_W-1:0]            rob_head_i,
    output logic [DEPTH-1:0]            grant_o,
    output logic                        valid_o,
    output logic [TAG_W-1:0]            tag_o
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0][TAG_W-1:0] age;
    logic [IDX_W-1:0]            best_idx;
    logic [TAG_W-1:0]            best_age;
    logic                        found;

    // Per-slot age relative to the ROB head.
    for (genvar g = 0; g < DEPTH; g++) begin : g_age
        assign age[g] = tags_i[g] - rob_head_i;
    end

    // Linear minimum search over ready slots.
    always_comb begin
        found    = 1'b0;
        best_idx = '0;
        best_age = '1;
        for (int i = 0; i < DEPTH; i++) begin
            if (ready_i[i] && (!found || age[i] < best_age)) begin
                found    = 1'b1;
                best_age = age[i];
                best_idx = IDX_W'(i);
            end
        end
    end

    // One-hot grant and the issuing tag.
    always_comb begin
        grant_o = '0;
        if (found) grant_o[best_idx] = 1'b1;
        valid_o = found;
        tag_o   = tags_i[best_idx];
    end

    // R7
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o) && ((grant_o & ~ready_i) == '0));
endmodule

// File: rtl/mdq_wakeup.sv
// mdq_wakeup: memory issue queue with dispatch-time dependence verdicts.
// Slots wake on matching store-resolve broadcasts or when no older store is
// unresolved; the oldest ready slot issues. Assumes tags are unique among
// live loads and the issue consumer always accepts the grant.
module mdq_wakeup
    import mdq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int TAG_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             disp_valid_i,
    input  logic [TAG_W-1:0] disp_rob_tag_i,
    input  logic [1:0]       disp_pred_i,
    input  logic [TAG_W-1:0] disp_store_tag_i,
    output logic             disp_ready_o,
    input  logic             st_res_valid_i,
    input  logic [TAG_W-1:0] st_res_tag_i,
    input  logic             old_st_valid_i,
    input  logic [TAG_W-1:0] old_st_tag_i,
    input  logic [TAG_W-1:0] rob_head_i,
    input  logic             flush_valid_i,
    input  logic [TAG_W-1:0] flush_tag_i,
    output logic             issue_valid_o,
    output logic [TAG_W-1:0] issue_rob_tag_o
);
    logic [DEPTH-1:0]            valid_vec, ready_vec, alloc_vec, grant_vec;
    logic [DEPTH-1:0][TAG_W-1:0] tag_vec;
    logic                        disp_drop, disp_fire;

    // A dispatch younger than an active flush is dropped.
    always_comb begin
        disp_drop = flush_valid_i &&
                    ((disp_rob_tag_i - rob_head_i) > (flush_tag_i - rob_head_i));
        disp_fire = disp_valid_i && disp_ready_o && !disp_drop;
    end

    mdq_alloc #(.DEPTH(DEPTH)) u_alloc (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (valid_vec),
        .fire_i  (disp_fire),
        .alloc_o (alloc_vec),
        .ready_o (disp_ready_o)
    );

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        mdq_slot #(.TAG_W(TAG_W)) u_slot (
            .clk            (clk),
            .rst_n          (rst_n),
            .alloc_i        (alloc_vec[s]),
            .alloc_tag_i    (disp_rob_tag_i),
            .alloc_pred_i   (mdq_pred_e'(disp_pred_i)),
            .alloc_stag_i   (disp_store_tag_i),
            .res_valid_i    (st_res_valid_i),
            .res_tag_i      (st_res_tag_i),
            .old_st_valid_i (old_st_valid_i),
            .old_st_tag_i   (old_st_tag_i),
            .rob_head_i     (rob_head_i),
            .flush_valid_i  (flush_valid_i),
            .flush_tag_i    (flush_tag_i),
            .issue_i        (grant_vec[s]),
            .valid_o        (valid_vec[s]),
            .tag_o          (tag_vec[s]),
            .ready_o        (ready_vec[s])
        );
    end

    mdq_oldest #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_oldest (
        .clk        (clk),
        .rst_n      (rst_n),
        .ready_i    (ready_vec),
        .tags_i     (tag_vec),
        .rob_head_i (rob_head_i),
        .grant_o    (grant_vec),
        .valid_o    (issue_valid_o),
        .tag_o      (issue_rob_tag_o)
    );

    // R9
    full_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!disp_ready_o && disp_valid_i && !issue_valid_o && !flush_valid_i)
        |=> $stable(valid_vec));

    // R1
    reset_empty_chk: assert property (@(posedge clk)
        !rst_n |=> (valid_vec == '0));
endmodule

// File: tb/mdq_wakeup_test.sv
`timescale 1ns/1ps
module mdq_wakeup_test;
    localparam int DEPTH = 8;
    localparam int TAG_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             disp_valid_i = 1'b0;
    logic [TAG_W-1:0] disp_rob_tag_i = '0;
    logic [1:0]       disp_pred_i = '0;
    logic [TAG_W-1:0] disp_store_tag_i = '0;
    logic             disp_ready_o;
    logic             st_res_valid_i = 1'b0;
    logic [TAG_W-1:0] st_res_tag_i = '0;
    logic             old_st_valid_i = 1'b0;
    logic [TAG_W-1:0] old_st_tag_i = '0;
    logic [TAG_W-1:0] rob_head_i = '0;
    logic             flush_valid_i = 1'b0;
    logic [TAG_W-1:0] flush_tag_i = '0;
    logic             issue_valid_o;
    logic [TAG_W-1:0] issue_rob_tag_o;

    int    checks = 0;
    int    fails  = 0;
    string cur_req = "R1";
    int    exp_q[$];
    string req_q[$];
    bit    done = 1'b0;

    always #2 clk = ~clk;

    mdq_wakeup #(.DEPTH(DEPTH), .TAG_W(TAG_W)) uut (.*);

    // Monitor: compare every issue against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && issue_valid_o) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL %s: unexpected issue tag %0d, expected none", cur_req, issue_rob_tag_o);
            end else begin
                automatic int    e = exp_q.pop_front();
                automatic string r = req_q.pop_front();
                if (int'(issue_rob_tag_o) != e) begin
                    fails++;
                    $display("FAIL %s: issue tag %0d, expected %0d", r, issue_rob_tag_o, e);
                end
            end
        end
    end

    task automatic expect_issue(input int tag, input string req);
        exp_q.push_back(tag);
        req_q.push_back(req);
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic dispatch(input int tag, input int pred, input int stag);
        disp_valid_i = 1'b1;
        disp_rob_tag_i = TAG_W'(tag);
        disp_pred_i = 2'(pred);
        disp_store_tag_i = TAG_W'(stag);
        tick();
        disp_valid_i = 1'b0;
    endtask

    task automatic resolve(input int tag);
        st_res_valid_i = 1'b1;
        st_res_tag_i = TAG_W'(tag);
        tick();
        st_res_valid_i = 1'b0;
    endtask

    task automatic end_scn(input string req);
        idle(4);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL %s: %0d expected issues missing, expected 0", req, exp_q.size());
            exp_q.delete();
            req_q.delete();
        end
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d, expected %0d", req, act, exp);
        end
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        idle(3);
        #1;
        // R1: reset state
        check("R1 disp_ready", int'(disp_ready_o), 1);
        check("R1 issue_valid", int'(issue_valid_o), 0);
        rst_n = 1'b1;
        idle(2);
        check("R1 idle after reset", int'(issue_valid_o), 0);

        // R2 and R10: free load passes an older unresolved store, not in its dispatch cycle
        cur_req = "R2";
        old_st_valid_i = 1'b1; old_st_tag_i = 6'd1;
        expect_issue(3, "R2");
        disp_valid_i = 1'b1; disp_rob_tag_i = 6'd3; disp_pred_i = 2'd0; disp_store_tag_i = '0;
        @(negedge clk);
        check("R10 no issue in dispatch cycle", int'(issue_valid_o), 0);
        tick();
        disp_valid_i = 1'b0;
        end_scn("R2");

        // R3: only the matching broadcast wakes a wait-for load
        cur_req = "R3";
        dispatch(4, 1, 10);
        idle(3);
        resolve(11);
        idle(3);
        expect_issue(4, "R3");
        resolve(10);
        end_scn("R3");

        // R3 and R4: one broadcast wakes all sharers; woken loads ignore older unresolved store
        cur_req = "R4";
        old_st_valid_i = 1'b1; old_st_tag_i = 6'd0;
        dispatch(6, 1, 12);
        dispatch(7, 1, 12);
        dispatch(8, 1, 13);
        idle(2);
        expect_issue(6, "R4");
        expect_issue(7, "R4");
        resolve(12);
        idle(4);
        expect_issue(8, "R3");
        resolve(13);
        end_scn("R4");

        // R5: resolve in the dispatch cycle wakes the new slot
        cur_req = "R5";
        expect_issue(9, "R5");
        st_res_valid_i = 1'b1; st_res_tag_i = 6'd20;
        dispatch(9, 1, 20);
        st_res_valid_i = 1'b0;
        end_scn("R5");

        // R6: wait-all boundary against the oldest unresolved store
        cur_req = "R6";
        old_st_valid_i = 1'b1; old_st_tag_i = 6'd15;
        expect_issue(14, "R6");
        dispatch(14, 2, 0);
        dispatch(20, 2, 0);
        dispatch(22, 3, 0);
        idle(3);
        expect_issue(20, "R6");
        old_st_tag_i = 6'd21;
        idle(3);
        expect_issue(22, "R6");
        old_st_valid_i = 1'b0;
        end_scn("R6");

        // R7: oldest first across the tag wrap
        cur_req = "R7";
        rob_head_i = 6'd60;
        old_st_valid_i = 1'b1; old_st_tag_i = 6'd60;
        dispatch(62, 2, 0);
        dispatch(1, 2, 0);
        dispatch(61, 2, 0);
        idle(2);
        expect_issue(61, "R7");
        expect_issue(62, "R7");
        expect_issue(1, "R7");
        old_st_valid_i = 1'b0;
        end_scn("R7");
        rob_head_i = 6'd0;

        // R8: flush removes younger slots and masks issue in the flush cycle
        cur_req = "R8";
        old_st_valid_i = 1'b1; old_st_tag_i = 6'd0;
        dispatch(5, 2, 0);
        dispatch(8, 2, 0);
        dispatch(11, 2, 0);
        flush_valid_i = 1'b1; flush_tag_i = 6'd8;
        tick();
        flush_valid_i = 1'b0;
        expect_issue(5, "R8");
        expect_issue(8, "R8");
        old_st_valid_i = 1'b0;
        end_scn("R8");
        dispatch(30, 0, 0);
        flush_valid_i = 1'b1; flush_tag_i = 6'd25;
        tick();
        flush_valid_i = 1'b0;
        end_scn("R8");

        // R9: full queue refuses dispatch
        cur_req = "R9";
        for (int i = 0; i < DEPTH; i++) dispatch(i, 1, 40);
        check("R9 disp_ready when full", int'(disp_ready_o), 0);
        dispatch(20, 0, 0);
        idle(4);
        for (int i = 0; i < DEPTH; i++) expect_issue(i, "R9");
        resolve(40);
        idle(DEPTH + 2);
        end_scn("R9");
        check("R9 disp_ready after drain", int'(disp_ready_o), 1);

        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule